// File: doc/BRIEF.md
# NAND Bus Strobe Timing Generator

This block drives the pins of an asynchronous NAND flash device for one single-byte bus cycle at a time. A request names a chip select and an offset inside that chip select's register window. The offset picks a command byte (CLE high), an address byte (ALE high) or a data byte. A data request may be a read or a write. Command and address requests are writes only.

Each cycle runs through four timed phases. In the setup phase the chip enable goes low and the strobe stays high. In the strobe phase WE# or RE# is low. In the recovery phase the strobe is high again and the chip enable is still low. In the extension phase the pins are released but the block stays busy. Every phase length is an 8-bit tick count. The counts are taken from two packed 32-bit timing words: one for the write side and one for the read side. Both words are captured when the request is accepted.

The flash ready/busy pin is brought in through a synchronizer and reported as a ready flag. Higher-level sequencing runs above this block: page transfers, error correction and DMA.

Top module: `nand_strobe_gen`

## Requirements
- R1: While reset is held and just after it, `busy` and `rd_valid` are 0, every `nand_ce_n` bit is 1, `nand_we_n` and `nand_re_n` are 1, and `nand_cle`, `nand_ale` and `nand_dq_oe` are 0.
- R2: Address bits [9:8] choose the chip select, and only that `nand_ce_n` bit goes low. Window offset 0x00 issues a command byte with `nand_cle` high. Offset 0x04 issues an address byte with `nand_ale` high. Offset 0x08 issues a data byte with neither high. CLE or ALE stays high for the whole time the chip enable is low.
- R3: A phase count n lasts T(n) cycles, where T(0)=1 and T(n)=n otherwise. After acceptance the chip enable is low with the strobe still high for T(write word bits 31:24) cycles.
- R4: On a write, WE# is low for T(write bits 7:0) cycles. It is then high for T(d) cycles with the chip enable still low, where d is bits 15:8 minus bits 7:0 when bits 15:8 are larger, and 0 otherwise. `nand_dq_oe` is high and `nand_dq_out` carries the request byte while WE# is low.
- R5: After the chip enable rises at the end of a write, `busy` stays high for T(write bits 23:16) more cycles.
- R6: On a read, RE# is low for the larger of T(read bits 15:8) and T(read bits 31:24). `nand_dq_in` is captured at the clock edge that ends the T(read bits 31:24)-th cycle of RE# low. `rd_valid` pulses for one cycle with that byte on `rd_data`.
- R7: After RE# rises, the chip enable stays low for T(read bits 23:16) cycles. After that, `busy` stays high for T(read bits 7:0) cycles.
- R8: `busy` rises in the cycle after acceptance and falls when the extension phase ends. A request presented while `busy` is high is dropped.
- R9: A request to any other offset, or a read of offset 0x00 or 0x04, starts no cycle. In that case `busy` and every pin stay idle.
- R10: Changing either timing word after acceptance does not alter the phase lengths of the cycle in progress.
- R11: `flash_ready` follows `nand_rb_n` two clock edges later.
- R12: WE# and RE# are never low together, and `nand_dq_oe` is never high during a read cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_read | input | 1 | 1 = read data byte, 0 = write |
| req_addr | input | 10 | [9:8] chip select, [7:0] window offset |
| req_wdata | input | 8 | Byte to write |
| wr_timing | input | 32 | Write-side timing word |
| rd_timing | input | 32 | Read-side timing word |
| busy | output | 1 | A cycle is in progress |
| rd_valid | output | 1 | One-cycle pulse, read byte ready |
| rd_data | output | 8 | Captured read byte |
| flash_ready | output | 1 | Synchronized ready/busy status |
| nand_ce_n | output | 4 | Chip enables, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Data bus out |
| nand_dq_oe | output | 1 | Data bus drive enable |
| nand_dq_in | input | 8 | Data bus in |
| nand_rb_n | input | 1 | Flash ready/busy pin |

## Verification
The bench drives a read data bus whose value changes on every RE# low cycle. If the block captured the byte one cycle early or late, the returned byte would differ from the expected one by one step. Zero counts, a write cycle length shorter than the pulse width, and an access time longer than the RE# low width are all tested. A wrong clamp in any of these cases would produce a zero-length or wrapped phase, and the measured low time would be far off. The bench rewrites the timing words mid-cycle and sends a request while a cycle is running. A design that did not latch the words, or that queued the late request, would show the wrong phase lengths or a second busy period. Invalid offsets and reads of the command or address offsets are also sent; a design that did not ignore them would lower a chip enable.

// File: rtl/nstg_pkg.sv
package nstg_pkg;
  localparam int FW = 8;
  localparam int TW = 4 * FW;

  localparam logic [7:0] OFS_CMD = 8'h00;
  localparam logic [7:0] OFS_ADR = 8'h04;
  localparam logic [7:0] OFS_DAT = 8'h08;

  typedef enum logic [2:0] {
    PH_IDLE, PH_SETUP, PH_STROBE, PH_RECOV, PH_EXTEND
  } phase_e;

  typedef enum logic [1:0] {K_CMD, K_ADR, K_DAT} kind_e;

  // slot 0 is the most significant byte of a timing word
  function automatic logic [FW-1:0] field_of(input logic [TW-1:0] w,
                                             input logic [1:0] slot);
    return w[TW-1-FW*slot -: FW];
  endfunction

  // a zero count still occupies one cycle
  function automatic logic [FW-1:0] ticks(input logic [FW-1:0] n);
    return (n == '0) ? FW'(1) : n;
  endfunction

  function automatic logic [FW-1:0] max_f(input logic [FW-1:0] a,
                                          input logic [FW-1:0] b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic [FW-1:0] gap_f(input logic [FW-1:0] cyc,
                                          input logic [FW-1:0] pw);
    return (cyc > pw) ? FW'(cyc - pw) : '0;
  endfunction
endpackage

// File: rtl/nstg_rb_sync.sv
module nstg_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[STAGES-2:0], d};
  end

  assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/nstg_phase_ctr.sv
module nstg_phase_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] remain,
  output logic         expired
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              remain <= '0;
    else if (load)           remain <= load_val;
    else if (remain != '0)   remain <= remain - W'(1);
  end

  assign expired = (remain == '0);
endmodule

// File: rtl/nstg_req_decode.sv
module nstg_req_decode
  import nstg_pkg::*;
#(
  parameter int CS_W     = 2,
  parameter int WIN_BITS = 8
) (
  input  logic                     valid,
  input  logic                     is_read,
  input  logic [CS_W+WIN_BITS-1:0] addr,
  output logic                     ok,
  output logic [CS_W-1:0]          cs,
  output kind_e                    kind
);
  logic [WIN_BITS-1:0] ofs;

  always_comb begin
    ofs  = addr[WIN_BITS-1:0];
    cs   = addr[CS_W+WIN_BITS-1:WIN_BITS];
    kind = K_DAT;
    ok   = 1'b0;
    if (ofs == WIN_BITS'(OFS_CMD)) begin
      kind = K_CMD;
      ok   = valid && !is_read;
    end else if (ofs == WIN_BITS'(OFS_ADR)) begin
      kind = K_ADR;
      ok   = valid && !is_read;
    end else if (ofs == WIN_BITS'(OFS_DAT)) begin
      kind = K_DAT;
      ok   = valid;
    end
  end
endmodule

// File: rtl/nand_strobe_gen.sv
module nand_strobe_gen
  import nstg_pkg::*;
#(
  parameter int CS_N     = 4,
  parameter int WIN_BITS = 8,
  parameter int DATA_W   = 8,
  localparam int CS_W    = $clog2(CS_N),
  localparam int ADDR_W  = CS_W + WIN_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_read,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [TW-1:0]     wr_timing,
  input  logic [TW-1:0]     rd_timing,
  output logic              busy,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              flash_ready,
  output logic [CS_N-1:0]   nand_ce_n,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic [DATA_W-1:0] nand_dq_out,
  output logic              nand_dq_oe,
  input  logic [DATA_W-1:0] nand_dq_in,
  input  logic              nand_rb_n
);
  phase_e            phase_q;
  logic [CS_W-1:0]   cs_q;
  kind_e             kind_q;
  logic              rd_q;
  logic [DATA_W-1:0] wdata_q;
  logic [TW-1:0]     wr_t_q, rd_t_q;

  logic              req_ok;
  logic [CS_W-1:0]   req_cs;
  kind_e             req_kind;

  // named internal events for the checker
  logic              accept, phase_done, sample_now;

  logic              ctr_load, ctr_expired;
  logic [FW-1:0]     ctr_val, ctr_remain;
  logic [FW-1:0]     setup_len, strobe_len, recov_len, ext_len, acc_len;

  nstg_req_decode #(.CS_W(CS_W), .WIN_BITS(WIN_BITS)) dec_i (
    .valid(req_valid), .is_read(req_read), .addr(req_addr),
    .ok(req_ok), .cs(req_cs), .kind(req_kind)
  );

  nstg_phase_ctr #(.W(FW)) ctr_i (
    .clk(clk), .rst_n(rst_n), .load(ctr_load), .load_val(ctr_val),
    .remain(ctr_remain), .expired(ctr_expired)
  );

  nstg_rb_sync #(.STAGES(2)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(nand_rb_n), .q(flash_ready)
  );

  // phase lengths; setup uses the live word, the rest the captured ones
  always_comb begin
    setup_len = ticks(field_of(wr_timing, 2'd0));
    acc_len   = ticks(field_of(rd_t_q, 2'd0));
    if (rd_q) begin
      strobe_len = max_f(ticks(field_of(rd_t_q, 2'd2)), acc_len);
      recov_len  = ticks(field_of(rd_t_q, 2'd1));
      ext_len    = ticks(field_of(rd_t_q, 2'd3));
    end else begin
      strobe_len = ticks(field_of(wr_t_q, 2'd3));
      recov_len  = ticks(gap_f(field_of(wr_t_q, 2'd2), field_of(wr_t_q, 2'd3)));
      ext_len    = ticks(field_of(wr_t_q, 2'd1));
    end
  end

  assign accept     = req_ok && (phase_q == PH_IDLE);
  assign phase_done = (phase_q != PH_IDLE) && ctr_expired;
  assign sample_now = (phase_q == PH_STROBE) && rd_q &&
                      (ctr_remain == FW'(strobe_len - acc_len));

  always_comb begin
    ctr_load = 1'b0;
    ctr_val  = '0;
    if (accept) begin
      ctr_load = 1'b1;
      ctr_val  = FW'(setup_len - FW'(1));
    end else if (phase_done) begin
      unique case (phase_q)
        PH_SETUP:  begin ctr_load = 1'b1; ctr_val = FW'(strobe_len - FW'(1)); end
        PH_STROBE: begin ctr_load = 1'b1; ctr_val = FW'(recov_len - FW'(1));  end
        PH_RECOV:  begin ctr_load = 1'b1; ctr_val = FW'(ext_len - FW'(1));    end
        default:   ctr_load = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cs_q    <= '0;
      kind_q  <= K_DAT;
      rd_q    <= 1'b0;
      wdata_q <= '0;
      wr_t_q  <= '0;
      rd_t_q  <= '0;
    end else if (accept) begin
      phase_q <= PH_SETUP;
      cs_q    <= req_cs;
      kind_q  <= req_kind;
      rd_q    <= req_read;
      wdata_q <= req_wdata;
      wr_t_q  <= wr_timing;
      rd_t_q  <= rd_timing;
    end else if (phase_done) begin
      unique case (phase_q)
        PH_SETUP:  phase_q <= PH_STROBE;
        PH_STROBE: phase_q <= PH_RECOV;
        PH_RECOV:  phase_q <= PH_EXTEND;
        default:   phase_q <= PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= sample_now;
      if (sample_now) rd_data <= nand_dq_in;
    end
  end

  logic pins_on, strobe_on;
  assign pins_on   = (phase_q == PH_SETUP) || (phase_q == PH_STROBE) ||
                     (phase_q == PH_RECOV);
  assign strobe_on = (phase_q == PH_STROBE);

  for (genvar g = 0; g < CS_N; g++) begin : g_ce
    assign nand_ce_n[g] = !(pins_on && (cs_q == CS_W'(g)));
  end

  assign busy        = (phase_q != PH_IDLE);
  assign nand_cle    = pins_on && (kind_q == K_CMD);
  assign nand_ale    = pins_on && (kind_q == K_ADR);
  assign nand_we_n   = !(strobe_on && !rd_q);
  assign nand_re_n   = !(strobe_on && rd_q);
  assign nand_dq_oe  = pins_on && !rd_q;
  assign nand_dq_out = wdata_q;
endmodule

// File: rtl/nand_strobe_gen_chk.sv
module nand_strobe_gen_chk #(
  parameter int CS_N = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            rd_valid,
  input logic            flash_ready,
  input logic [CS_N-1:0] nand_ce_n,
  input logic            nand_cle,
  input logic            nand_ale,
  input logic            nand_we_n,
  input logic            nand_re_n,
  input logic            nand_dq_oe,
  input logic            nand_rb_n,
  input logic            accept
);
  // R12
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));

  // R12
  no_drive_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> !nand_dq_oe);

  // R2
  ce_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~nand_ce_n));

  // R2
  latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));

  // R8
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  // R5
  release_before_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (&nand_ce_n));

  // R6
  rdv_after_re_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(!nand_re_n));

  // R3
  setup_before_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nand_we_n) |-> !$past(&nand_ce_n));

  // R11
  ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flash_ready) |-> $past(nand_rb_n, 2));

  // R11
  ready_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flash_ready) |-> !$past(nand_rb_n, 2));
endmodule

bind nand_strobe_gen nand_strobe_gen_chk #(.CS_N(CS_N)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .rd_valid(rd_valid),
  .flash_ready(flash_ready), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
  .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
  .nand_dq_oe(nand_dq_oe), .nand_rb_n(nand_rb_n), .accept(accept)
);

// File: tb/nand_strobe_gen_tb.sv
module nand_strobe_gen_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_read = 1'b0;
  logic [9:0]  req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic [31:0] wr_timing = '0, rd_timing = '0;
  logic        busy, rd_valid, flash_ready;
  logic [7:0]  rd_data, nand_dq_out;
  logic [3:0]  nand_ce_n;
  logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [7:0]  nand_dq_in = '0;
  logic        nand_rb_n = 1'b1;

  int tests = 0, fails = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_strobe_gen dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_read(req_read),
    .req_addr(req_addr), .req_wdata(req_wdata), .wr_timing(wr_timing),
    .rd_timing(rd_timing), .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data),
    .flash_ready(flash_ready), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
    .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
    .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe),
    .nand_dq_in(nand_dq_in), .nand_rb_n(nand_rb_n)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      tests++; fails++;
      $display("FAIL R8 watchdog act=%0d exp=%0d", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int tl(input logic [7:0] n);
    return (n < 8'd1) ? 1 : int'(n);
  endfunction

  function automatic int fb(input logic [31:0] w, input int hi);
    return int'(w[hi -: 8]);
  endfunction

  task automatic run_req(input bit rd, input logic [9:0] addr, input logic [7:0] wd,
                         input logic [31:0] wt, input logic [31:0] rt,
                         input logic [7:0] base, input bit poke, input bit swap_t);
    int cs_i, ofs, s_e, p_e, h_e, x_e, a_e, cle_e, ale_e;
    int busy_c, pre_c, str_c, post_c, cle_c, ale_c, rdv_c, lowc, guard, bad_other, bad_bus;
    bit valid, seen_str;
    logic [7:0] rdv_d;
    cs_i = int'(addr[9:8]); ofs = int'(addr[7:0]);
    valid = (ofs == 8 && 1'b1) || (!rd && (ofs == 0 || ofs == 4));
    s_e = tl(wt[31:24]);
    if (rd) begin
      a_e = tl(rt[31:24]);
      p_e = (tl(rt[15:8]) > a_e) ? tl(rt[15:8]) : a_e;
      h_e = tl(rt[23:16]); x_e = tl(rt[7:0]);
    end else begin
      a_e = 0;
      p_e = tl(wt[7:0]);
      h_e = (fb(wt, 15) > fb(wt, 7)) ? fb(wt, 15) - fb(wt, 7) : 1;
      x_e = tl(wt[23:16]);
    end
    cle_e = (ofs == 0) ? s_e + p_e + h_e : 0;
    ale_e = (ofs == 4) ? s_e + p_e + h_e : 0;
    @(negedge clk);
    req_valid = 1'b1; req_read = rd; req_addr = addr; req_wdata = wd;
    wr_timing = wt; rd_timing = rt;
    @(negedge clk);
    req_valid = 1'b0;
    busy_c = 0; pre_c = 0; str_c = 0; post_c = 0; cle_c = 0; ale_c = 0;
    rdv_c = 0; lowc = 0; guard = 0; bad_other = 0; bad_bus = 0; seen_str = 0; rdv_d = '0;
    while (busy === 1'b1 && guard < 5000) begin
      guard++; busy_c++;
      for (int k = 0; k < 4; k++) if (k != cs_i && nand_ce_n[k] == 1'b0) bad_other++;
      if (!nand_we_n && !nand_re_n) bad_bus++;
      if (rd && (nand_dq_oe || !nand_we_n)) bad_bus++;
      if (!rd && !nand_re_n) bad_bus++;
      if (nand_ce_n[cs_i] == 1'b0) begin
        if ((rd ? !nand_re_n : !nand_we_n)) begin
          str_c++; seen_str = 1;
          if (!rd && (!nand_dq_oe || nand_dq_out !== wd)) bad_bus++;
        end else if (seen_str) post_c++;
        else pre_c++;
        if (nand_cle) cle_c++;
        if (nand_ale) ale_c++;
      end
      if (rd_valid) begin rdv_c++; rdv_d = rd_data; end
      if (nand_re_n == 1'b0) begin lowc++; nand_dq_in = base + 8'(lowc); end
      else lowc = 0;
      if (swap_t && guard == 1) begin wr_timing = ~wt; rd_timing = ~rt; end
      req_valid = (poke && guard == 2);
      @(negedge clk);
    end
    req_valid = 1'b0;
    if (!valid) begin
      // R9: ignored request leaves everything idle
      check(busy_c == 0 && &nand_ce_n, "R9 ignored offset busy cycles", busy_c, 0);
      return;
    end
    // R8 busy span, R5/R7 extension included
    check(busy_c == s_e + p_e + h_e + x_e, swap_t ? "R10 busy span" : "R8 busy span",
          busy_c, s_e + p_e + h_e + x_e);
    check(pre_c == s_e, "R3 setup cycles", pre_c, s_e);
    check(str_c == p_e, rd ? "R6 RE low cycles" : "R4 WE low cycles", str_c, p_e);
    check(post_c == h_e, rd ? "R7 RE high hold" : "R4 WE high recovery", post_c, h_e);
    check(cle_c == cle_e && ale_c == ale_e, "R2 CLE/ALE cycles", cle_c + ale_c, cle_e + ale_e);
    check(bad_other == 0, "R2 other chip enables", bad_other, 0);
    check(bad_bus == 0, "R12 strobe/bus drive", bad_bus, 0);
    if (rd) begin
      check(rdv_c == 1, "R6 rd_valid pulses", rdv_c, 1);
      check(rdv_d == base + 8'(a_e), "R6 captured byte", int'(rdv_d), int'(base + 8'(a_e)));
    end else check(rdv_c == 0, "R5 no rd_valid on write", rdv_c, 0);
    if (poke) begin
      for (int k = 0; k < 3; k++) begin
        check(busy == 1'b0, "R8 request during busy dropped", int'(busy), 0);
        @(negedge clk);
      end
    end
  endtask

  function automatic logic [31:0] rnd_word();
    return {8'($urandom_range(0, 6)), 8'($urandom_range(0, 6)),
            8'($urandom_range(0, 6)), 8'($urandom_range(0, 6))};
  endfunction

  initial begin
    int unsigned seed_set;
    seed_set = $urandom(32'd715);
    repeat (3) @(negedge clk);
    // R1 during reset
    check(busy == 0 && &nand_ce_n && nand_we_n && nand_re_n && !nand_cle && !nand_ale
          && !nand_dq_oe && !rd_valid, "R1 reset idle pins", int'(nand_ce_n), 15);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 0 && &nand_ce_n && nand_we_n && nand_re_n && !nand_dq_oe,
          "R1 idle after reset", int'(busy), 0);
    @(negedge clk);
    check(flash_ready == 1'b1, "R11 ready after reset", int'(flash_ready), 1);

    // directed corners
    run_req(0, 10'h000, 8'hA5, 32'h0000_0000, 32'h0, 8'h00, 0, 0); // all zero counts
    run_req(0, 10'h104, 8'h3C, 32'h0203_0105, 32'h0, 8'h00, 0, 0); // cyc < pw
    run_req(0, 10'h208, 8'h5A, 32'h0102_0603, 32'h0, 8'h00, 0, 0);
    run_req(1, 10'h308, 8'h00, 32'h0300_0000, 32'h0502_0201, 8'h10, 0, 0); // acc > low
    run_req(1, 10'h008, 8'h00, 32'h0100_0000, 32'h0201_0703, 8'h40, 0, 0); // acc < low
    run_req(1, 10'h108, 8'h00, 32'h0000_0000, 32'h0000_0000, 8'hFE, 0, 0);
    run_req(0, 10'h2FF, 8'h11, 32'hFFFF_FFFF, 32'h0, 8'h00, 0, 0); // max counts
    run_req(1, 10'h108, 8'h00, 32'h0200_0000, 32'hFF01_0301, 8'hF0, 0, 0); // byte wrap
    run_req(0, 10'h10C, 8'h22, 32'h0101_0101, 32'h0, 8'h00, 0, 0); // bad offset
    run_req(1, 10'h000, 8'h00, 32'h0101_0101, 32'h0101_0101, 8'h00, 0, 0); // read of cmd
    run_req(1, 10'h304, 8'h00, 32'h0101_0101, 32'h0101_0101, 8'h00, 0, 0); // read of addr
    run_req(0, 10'h204, 8'h77, 32'h0203_0402, 32'h0, 8'h00, 1, 1); // poke + swap
    run_req(1, 10'h308, 8'h00, 32'h0200_0000, 32'h0302_0402, 8'h20, 1, 1);

    // R11 synchronizer latency
    @(negedge clk); nand_rb_n = 1'b0;
    @(negedge clk); check(flash_ready == 1'b1, "R11 ready one edge", int'(flash_ready), 1);
    @(negedge clk); check(flash_ready == 1'b0, "R11 busy two edges", int'(flash_ready), 0);
    nand_rb_n = 1'b1;
    @(negedge clk); check(flash_ready == 1'b0, "R11 still busy one edge", int'(flash_ready), 0);
    @(negedge clk); check(flash_ready == 1'b1, "R11 ready two edges", int'(flash_ready), 1);

    // constrained random mix
    for (int n = 0; n < 60; n++) begin
      logic [7:0] ofs_pick;
      int sel;
      sel = $urandom_range(0, 4);
      ofs_pick = (sel == 0) ? 8'h00 : (sel == 1) ? 8'h04 : (sel == 4) ? 8'h0C : 8'h08;
      run_req(1'($urandom_range(0, 1)), {2'($urandom_range(0, 3)), ofs_pick},
              8'($urandom), rnd_word(), rnd_word(), 8'($urandom),
              1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule